// File: doc/BRIEF.md
# Two-Tap Periodic Interrupt Generator

This block turns one free-running binary prescaler into two periodic interrupt sources. The slow clock increments the prescaler on every cycle. Two tap selectors pick which power-of-two boundary of the prescaler counts as a time-out. The time-base tap is chosen by a 2-bit input and spans divisors from 2^TB_BASE to 2^(TB_BASE+3), which is 2^12 to 2^15 by default. The real-time tap is chosen by a 3-bit field held in an 8-bit control register and spans 2^RT_BASE to 2^(RT_BASE+7), which is 2^8 to 2^15 by default.

Each time-out sets a sticky pending flag for its source. When a source's flag is set, its enable is high and the processor's return stack is not full, the block issues a one-cycle call strobe with that source's fixed vector address. The time-base vector is 0x010 and the real-time vector is 0x018. The pending flag is cleared in the same cycle that the call is taken. Software can also clear either flag. The prescaler is never restarted when a tap selection changes, so both sources stay phase-locked to one count.

Top module: `periodic_tap_irq`

## Requirements
- R1: While reset is asserted, both pending flags, the call strobe, the call vector and the real-time selection all read zero.
- R2: With time-base selection s (0..3), time-base calls that are not blocked occur exactly 2^(TB_BASE+s) cycles apart.
- R3: With real-time code c (0..7), real-time calls that are not blocked occur exactly 2^(RT_BASE+c) cycles apart. Code 0 is the shortest period, and each increment doubles it.
- R4: A write to the control register loads only data bits [2:0] into the real-time selection, which is readable on `rt_sel`. Bits [7:3] have no effect.
- R5: A time-base call drives `call_stb` high for one cycle with `call_vec` = 0x010.
- R6: A real-time call drives `call_stb` high for one cycle with `call_vec` = 0x018.
- R7: No call is issued while `stack_full` is high or while the source's enable is low. A request pending in either case is called on the cycle after the block is unblocked.
- R8: A pending flag stays set until its call is taken or its clear input is pulsed. A clear takes effect at the next clock edge. A time-out in the same cycle as a clear wins.
- R9: When both sources are pending and allowed, the time-base call is issued first and the real-time call on the following cycle.
- R10: Changing either tap selection does not restart the prescaler. The next time-out falls on the new tap's boundary of the count that is already running.
- R11: Each time-out produces at most one call, because taking the call clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock that advances the prescaler |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tb_sel | input | TB_SEL_W | Time-base tap selection |
| tb_ie | input | 1 | Time-base interrupt enable |
| rt_ie | input | 1 | Real-time interrupt enable |
| rt_ctrl_we | input | 1 | Write strobe for the real-time control register |
| rt_ctrl_wdata | input | CTRL_W | Control register write data; only the low RT_SEL_W bits are kept |
| tb_flag_clr | input | 1 | Software clear of the time-base pending flag |
| rt_flag_clr | input | 1 | Software clear of the real-time pending flag |
| stack_full | input | 1 | High when the return stack cannot accept a call |
| rt_sel | output | RT_SEL_W | Current real-time selection code |
| tb_flag | output | 1 | Time-base request pending |
| rt_flag | output | 1 | Real-time request pending |
| call_stb | output | 1 | One-cycle interrupt call strobe |
| call_vec | output | ADDR_W | Vector address of the call, zero when idle |

## Verification
The assertions check four properties on every cycle: no strobe follows a cycle with a full stack, a real-time call never overtakes an allowed time-base request, a pending flag never drops without a take or a clear, and the control register holds its value between writes. Whether the periods are exact, whether a new selection lands on the running prescaler's phase, and whether the two vectors come out in the right order can only be shown by the bench's scenarios. The bench first measures the prescaler phase once. It then sweeps every code of both taps against that phase, after changing the selection without any reset.

// File: rtl/ptg_pkg.sv
package ptg_pkg;

  typedef enum logic [1:0] {
    SRC_IDLE = 2'd0,
    SRC_TB   = 2'd1,
    SRC_RT   = 2'd2
  } src_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ptg_prescaler.sv
module ptg_prescaler #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b1;
    cnt_d  = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/ptg_tap_sel.sv
module ptg_tap_sel #(
  parameter int CNT_W = 15,
  parameter int BASE  = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);

  localparam int NCODE = 1 << SEL_W;
  localparam int TOP   = BASE + NCODE - 1;

  logic [NCODE-1:0] hit;

  for (genvar g = 0; g < NCODE; g++) begin : g_tap
    assign hit[g] = &cnt[BASE+g-1:0];
  end

  if (TOP < CNT_W) begin : g_spare
    logic cnt_unused_hi;
    assign cnt_unused_hi = ^cnt[CNT_W-1:TOP];
  end

  assign tick = hit[sel];

  // R2, R3: a tap boundary is never hit on two cycles in a row
  a_r3_tick_isolated: assert property (@(posedge clk) disable iff (!rst_ni)
    tick |=> !tick);

endmodule

// File: rtl/ptg_req_flag.sv
module ptg_req_flag (
  input  logic clk,
  input  logic rst_ni,
  input  logic set,
  input  logic take,
  input  logic sw_clr,
  output logic flag
);

  logic flag_q;
  logic flag_d;
  logic flag_en;

  always_comb begin
    flag_en = set | take | sw_clr;
    flag_d  = set | (flag_q & ~take & ~sw_clr);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_ni)
    (flag && !take && !sw_clr) |=> flag);

  a_r11_drop_on_take: assert property (@(posedge clk) disable iff (!rst_ni)
    (take && !set) |=> !flag);

endmodule

// File: rtl/ptg_arbiter.sv
module ptg_arbiter
  import ptg_pkg::*;
#(
  parameter int                ADDR_W = 12,
  parameter logic [ADDR_W-1:0] TB_VEC = 'h010,
  parameter logic [ADDR_W-1:0] RT_VEC = 'h018
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              tb_req,
  input  logic              rt_req,
  input  logic              stack_full,
  output logic              take_tb,
  output logic              take_rt,
  output logic              call_stb,
  output logic [ADDR_W-1:0] call_vec
);

  src_e              grant;
  logic              stb_d;
  logic              stb_q;
  logic [ADDR_W-1:0] vec_d;
  logic [ADDR_W-1:0] vec_q;

  always_comb begin
    grant = SRC_IDLE;
    if (!stack_full) begin
      if (tb_req) begin
        grant = SRC_TB;
      end else if (rt_req) begin
        grant = SRC_RT;
      end
    end
  end

  always_comb begin
    take_tb = (grant == SRC_TB);
    take_rt = (grant == SRC_RT);
    stb_d   = (grant != SRC_IDLE);
    case (grant)
      SRC_TB:  vec_d = TB_VEC;
      SRC_RT:  vec_d = RT_VEC;
      default: vec_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_q <= 1'b0;
      vec_q <= '0;
    end else begin
      stb_q <= stb_d;
      vec_q <= vec_d;
    end
  end

  assign call_stb = stb_q;
  assign call_vec = vec_q;

  a_r7_no_call_when_full: assert property (@(posedge clk) disable iff (!rst_ni)
    call_stb |-> $past(!stack_full));

  a_r9_tb_first: assert property (@(posedge clk) disable iff (!rst_ni)
    (call_stb && call_vec == RT_VEC) |-> $past(!tb_req));

  a_r5_known_vec: assert property (@(posedge clk) disable iff (!rst_ni)
    call_stb |-> (call_vec == TB_VEC || call_vec == RT_VEC));

  a_r6_idle_vec: assert property (@(posedge clk) disable iff (!rst_ni)
    !call_stb |-> (call_vec == '0));

endmodule

// File: rtl/periodic_tap_irq.sv
module periodic_tap_irq
  import ptg_pkg::*;
#(
  parameter int                TB_BASE  = 12,
  parameter int                TB_SEL_W = 2,
  parameter int                RT_BASE  = 8,
  parameter int                RT_SEL_W = 3,
  parameter int                CTRL_W   = 8,
  parameter int                ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] TB_VEC   = 'h010,
  parameter logic [ADDR_W-1:0] RT_VEC   = 'h018
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [TB_SEL_W-1:0] tb_sel,
  input  logic                tb_ie,
  input  logic                rt_ie,
  input  logic                rt_ctrl_we,
  input  logic [CTRL_W-1:0]   rt_ctrl_wdata,
  input  logic                tb_flag_clr,
  input  logic                rt_flag_clr,
  input  logic                stack_full,
  output logic [RT_SEL_W-1:0] rt_sel,
  output logic                tb_flag,
  output logic                rt_flag,
  output logic                call_stb,
  output logic [ADDR_W-1:0]   call_vec
);

  localparam int TB_TOP = TB_BASE + (1 << TB_SEL_W) - 1;
  localparam int RT_TOP = RT_BASE + (1 << RT_SEL_W) - 1;
  localparam int CNT_W  = imax(TB_TOP, RT_TOP);

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_ni = rst_sync_q[1];

  // real-time selection register: only the low field is kept
  logic [RT_SEL_W-1:0] rt_sel_q;
  logic [RT_SEL_W-1:0] rt_sel_d;
  logic                rt_sel_en;
  logic                ctrl_unused_hi;

  always_comb begin
    rt_sel_en = rt_ctrl_we;
    rt_sel_d  = rt_ctrl_wdata[RT_SEL_W-1:0];
  end

  assign ctrl_unused_hi = ^rt_ctrl_wdata[CTRL_W-1:RT_SEL_W];

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rt_sel_q <= '0;
    end else if (rt_sel_en) begin
      rt_sel_q <= rt_sel_d;
    end
  end

  assign rt_sel = rt_sel_q;

  a_r4_sel_holds: assert property (@(posedge clk) disable iff (!rst_ni)
    !rt_ctrl_we |=> $stable(rt_sel));

  // shared prescaler and the two taps
  logic [CNT_W-1:0] cnt;
  logic             tb_tick;
  logic             rt_tick;

  ptg_prescaler #(.CNT_W(CNT_W)) u_pre (
    .clk    (clk),
    .rst_ni (rst_ni),
    .cnt    (cnt)
  );

  ptg_tap_sel #(.CNT_W(CNT_W), .BASE(TB_BASE), .SEL_W(TB_SEL_W)) u_tb_tap (
    .clk    (clk),
    .rst_ni (rst_ni),
    .cnt    (cnt),
    .sel    (tb_sel),
    .tick   (tb_tick)
  );

  ptg_tap_sel #(.CNT_W(CNT_W), .BASE(RT_BASE), .SEL_W(RT_SEL_W)) u_rt_tap (
    .clk    (clk),
    .rst_ni (rst_ni),
    .cnt    (cnt),
    .sel    (rt_sel_q),
    .tick   (rt_tick)
  );

  // pending flags
  logic take_tb;
  logic take_rt;

  ptg_req_flag u_tb_flag (
    .clk    (clk),
    .rst_ni (rst_ni),
    .set    (tb_tick),
    .take   (take_tb),
    .sw_clr (tb_flag_clr),
    .flag   (tb_flag)
  );

  ptg_req_flag u_rt_flag (
    .clk    (clk),
    .rst_ni (rst_ni),
    .set    (rt_tick),
    .take   (take_rt),
    .sw_clr (rt_flag_clr),
    .flag   (rt_flag)
  );

  // call issue
  ptg_arbiter #(.ADDR_W(ADDR_W), .TB_VEC(TB_VEC), .RT_VEC(RT_VEC)) u_arb (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .tb_req     (tb_flag & tb_ie),
    .rt_req     (rt_flag & rt_ie),
    .stack_full (stack_full),
    .take_tb    (take_tb),
    .take_rt    (take_rt),
    .call_stb   (call_stb),
    .call_vec   (call_vec)
  );

endmodule

// File: tb/periodic_tap_irq_tb_top.sv
module periodic_tap_irq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int TB_B = 4;
  localparam int RT_B = 2;
  localparam int VTB  = 'h010;
  localparam int VRT  = 'h018;

  logic        clk;
  logic        rst_n;
  logic [1:0]  tb_sel;
  logic        tb_ie;
  logic        rt_ie;
  logic        rt_ctrl_we;
  logic [7:0]  rt_ctrl_wdata;
  logic        tb_flag_clr;
  logic        rt_flag_clr;
  logic        stack_full;
  logic [2:0]  rt_sel;
  logic        tb_flag;
  logic        rt_flag;
  logic        call_stb;
  logic [11:0] call_vec;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int t_ref = 0;

  periodic_tap_irq #(.TB_BASE(TB_B), .RT_BASE(RT_B)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .tb_sel        (tb_sel),
    .tb_ie         (tb_ie),
    .rt_ie         (rt_ie),
    .rt_ctrl_we    (rt_ctrl_we),
    .rt_ctrl_wdata (rt_ctrl_wdata),
    .tb_flag_clr   (tb_flag_clr),
    .rt_flag_clr   (rt_flag_clr),
    .stack_full    (stack_full),
    .rt_sel        (rt_sel),
    .tb_flag       (tb_flag),
    .rt_flag       (rt_flag),
    .call_stb      (call_stb),
    .call_vec      (call_vec)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_call(input int limit, output int t, output int v, output bit got);
    got = 1'b0; t = -1; v = -1;
    for (int i = 0; i < limit && !got; i++) begin
      @(negedge clk);
      if (call_stb) begin
        got = 1'b1; t = cyc; v = int'(call_vec);
      end
    end
  endtask

  task automatic quiet(input int n, input string req);
    int spur = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (call_stb) spur++;
    end
    chk(spur == 0, req, spur, 0, "calls while blocked");
  endtask

  // clear one flag, then unblock the stack one cycle later
  task automatic arm(input bit is_tb, output int s);
    s = cyc;
    if (is_tb) tb_flag_clr = 1'b1; else rt_flag_clr = 1'b1;
    @(negedge clk);
    tb_flag_clr = 1'b0; rt_flag_clr = 1'b0; stack_full = 1'b0;
  endtask

  function automatic int aligned(input int from, input int p);
    int n = from;
    while (((n - t_ref) % p) != 0) n++;
    return n;
  endfunction

  task automatic write_ctrl(input logic [7:0] d);
    rt_ctrl_wdata = d; rt_ctrl_we = 1'b1;
    @(negedge clk);
    rt_ctrl_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic rt_trial(input int code, input int junk);
    int s, e, t, v, p; bit got;
    stack_full = 1'b1;
    write_ctrl({junk[4:0], code[2:0]});
    chk(int'(rt_sel) == code, "R4", int'(rt_sel), code, "rt_sel after write with high bits");
    repeat (3 + code) @(negedge clk);
    arm(1'b0, s);
    p = 1 << (RT_B + code);
    e = aligned(s + 2, p);
    wait_call(p + 8, t, v, got);
    chk(got && t == e, "R10", t, e, "first call after reselect on running phase");
    chk(v == VRT, "R6", v, VRT, "real-time vector");
    wait_call(p + 8, t, v, got);
    stack_full = 1'b1;
    chk(got && t == e + p, "R3", t, e + p, "real-time call spacing");
    chk(got && t == e + p, "R11", t, e + p, "single call per time-out");
  endtask

  task automatic tb_trial(input int sel);
    int s, e, t, v, p; bit got;
    stack_full = 1'b1;
    tb_sel = sel[1:0];
    repeat (4 + sel) @(negedge clk);
    arm(1'b1, s);
    p = 1 << (TB_B + sel);
    e = aligned(s + 2, p);
    wait_call(p + 8, t, v, got);
    chk(got && t == e, "R10", t, e, "time-base first call on running phase");
    chk(v == VTB, "R5", v, VTB, "time-base vector");
    wait_call(p + 8, t, v, got);
    stack_full = 1'b1;
    chk(got && t == e + p, "R2", t, e + p, "time-base call spacing");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int s, t, v, drops, r, e; bit got;
    rst_n = 1'b0; tb_sel = 2'd0; tb_ie = 1'b0; rt_ie = 1'b0;
    rt_ctrl_we = 1'b0; rt_ctrl_wdata = 8'h00;
    tb_flag_clr = 1'b0; rt_flag_clr = 1'b0; stack_full = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!tb_flag && !rt_flag, "R1", {30'd0, tb_flag, rt_flag}, 0, "flags in reset");
    chk(!call_stb, "R1", int'(call_stb), 0, "strobe in reset");
    chk(call_vec == 12'h0, "R1", int'(call_vec), 0, "vector in reset");
    chk(rt_sel == 3'd0, "R1", int'(rt_sel), 0, "selection in reset");
    rst_n = 1'b1;

    // R7: disabled and blocked sources never call
    quiet(600, "R7");

    // R4: high bits of the control word are dropped
    write_ctrl(8'hFD);
    chk(rt_sel == 3'd5, "R4", int'(rt_sel), 5, "0xFD keeps code 5");
    write_ctrl(8'h02);
    chk(rt_sel == 3'd2, "R4", int'(rt_sel), 2, "0x02 keeps code 2");

    // measure the prescaler phase once with the longest real-time tap
    rt_ie = 1'b1;
    write_ctrl(8'h07);
    arm(1'b0, s);
    wait_call(1100, t, v, got);
    stack_full = 1'b1;
    chk(got && v == VRT, "R6", v, VRT, "reference real-time call");
    t_ref = t;

    // R3, R10: sweep all real-time codes without reset
    rt_trial(3, 21); rt_trial(0, 9);  rt_trial(7, 30); rt_trial(5, 1);
    rt_trial(1, 17); rt_trial(6, 4);  rt_trial(2, 31); rt_trial(4, 12);

    // R2, R10: sweep all time-base selections
    rt_ie = 1'b0; tb_ie = 1'b1;
    tb_trial(2); tb_trial(0); tb_trial(3); tb_trial(1);

    // R7, R9: both pending behind a full stack, then released
    write_ctrl(8'h00);
    tb_sel = 2'd3; tb_ie = 1'b1; rt_ie = 1'b1; stack_full = 1'b1;
    quiet(140, "R7");
    chk(tb_flag && rt_flag, "R8", {30'd0, tb_flag, rt_flag}, 3, "both requests held pending");
    while (((cyc + 2 - t_ref) % 128) == 0 || ((cyc + 1 - t_ref) % 128) == 0) @(negedge clk);
    r = cyc;
    stack_full = 1'b0;
    @(negedge clk);
    chk(call_stb && call_vec == 12'h010 && cyc == r + 1, "R9", int'(call_vec), VTB, "first of two pending");
    @(negedge clk);
    chk(call_stb && call_vec == 12'h018, "R9", int'(call_vec), VRT, "second of two pending");
    stack_full = 1'b1; tb_ie = 1'b0; rt_ie = 1'b0;

    // R7: pending while disabled, called once enabled
    tb_sel = 2'd0; stack_full = 1'b0;
    for (int i = 0; i < 40 && !tb_flag; i++) @(negedge clk);
    chk(tb_flag, "R8", int'(tb_flag), 1, "time-base pending while disabled");
    quiet(5, "R7");
    while (((cyc + 2 - t_ref) % 16) == 0 || ((cyc + 3 - t_ref) % 16) == 0) @(negedge clk);
    e = cyc;
    tb_ie = 1'b1;
    @(negedge clk);
    chk(call_stb && call_vec == 12'h010 && cyc == e + 1, "R7", int'(call_stb), 1, "call on cycle after enable");
    tb_ie = 1'b0;
    @(negedge clk);
    chk(!tb_flag, "R11", int'(tb_flag), 0, "flag cleared by taken call");

    // R8: sticky flag held, then software clear
    write_ctrl(8'h07);
    rt_flag_clr = 1'b1;
    @(negedge clk);
    rt_flag_clr = 1'b0;
    for (int i = 0; i < 600 && !rt_flag; i++) @(negedge clk);
    chk(rt_flag, "R8", int'(rt_flag), 1, "real-time flag raised");
    drops = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!rt_flag) drops++;
      if (call_stb) drops++;
    end
    chk(drops == 0, "R8", drops, 0, "flag stays set while disabled");
    rt_flag_clr = 1'b1;
    @(negedge clk);
    rt_flag_clr = 1'b0;
    chk(!rt_flag, "R8", int'(rt_flag), 0, "software clear");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule